// File: doc/BRIEF.md
# Dual-ADC Result FIFO Write Arbiter

This block takes finished conversion results from two analog-to-digital converter units, called unit A and unit B, and writes each one into one of four result FIFOs. Every result comes with a 2-bit FIFO selector taken from the command that produced it. When both units target different FIFOs, both results are written in the same cycle. When both units target the same FIFO in the same cycle, the block writes A's result first. B's result waits one cycle in a one-entry holding register. A result is never dropped because of a collision.

Both result inputs are valid/ready streams. A result is accepted on a rising clock edge where its valid and ready are both high. The two ready outputs depend only on the holding register, never on the input valids. Both readies go low for exactly one cycle, the cycle in which the held result drains. A producer may hold valid high while ready is low. Nothing is taken until ready returns. The four FIFOs are included as an 8-deep model. Each FIFO has a pop input, a head-of-queue output and a sticky overflow flag, so that ordering and full handling can be observed. Each FIFO write strobe and the entry being written are also brought out.

Top module: `adc_result_router`

## Requirements
- R1: A stored entry is DW+5 bits wide, packed as {unit, channel[3:0], data[DW-1:0]}. The unit bit is 0 for unit A and 1 for unit B. The channel tag and the data are copied unchanged from the accepted input.
- R2: If A and B are both accepted in one cycle with different selectors, both FIFOs are written in that same cycle. No more than two FIFO write strobes are ever high together.
- R3: If A and B are both accepted in one cycle with equal selectors, A's entry is written in that cycle and B's entry is written to the same FIFO in the next cycle. In that next cycle, that is the only write.
- R4: In the cycle after a same-selector collision, a_ready and b_ready are both low, and any valid input is not taken. In the following cycle, both readies are high again.
- R5: A result accepted with no same-selector collision is written in the cycle it is accepted. Results therefore enter a FIFO in the order in which they were accepted.
- R6: Each FIFO returns its entries first-in first-out. fifo_rd_valid[k] is high exactly when FIFO k holds at least one entry, and fifo_rd_data shows the oldest entry. A pop while empty has no effect.
- R7: A write to a FIFO that already holds 8 entries is discarded, even if a pop occurs in the same cycle. It sets fifo_ovf[k], which stays set until reset.
- R8: After reset, both readies are high, every FIFO is empty, all overflow flags are clear and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_valid | input | 1 | Unit A result valid |
| a_ready | output | 1 | Unit A result accepted when high with a_valid |
| a_data | input | DW | Unit A conversion data |
| a_chan | input | 4 | Unit A channel tag |
| a_sel | input | 2 | Unit A target FIFO |
| b_valid | input | 1 | Unit B result valid |
| b_ready | output | 1 | Unit B result accepted when high with b_valid |
| b_data | input | DW | Unit B conversion data |
| b_chan | input | 4 | Unit B channel tag |
| b_sel | input | 2 | Unit B target FIFO |
| fifo_wr_en | output | 4 | Per-FIFO write strobe |
| fifo_wr_entry | output | 4*(DW+5) | Entry being written, slice k for FIFO k |
| fifo_rd_pop | input | 4 | Per-FIFO pop request |
| fifo_rd_valid | output | 4 | FIFO k is non-empty |
| fifo_rd_data | output | 4*(DW+5) | Oldest entry of FIFO k, slice k |
| fifo_ovf | output | 4 | Sticky per-FIFO overflow flag |

## Verification
The properties assume that the selectors are only meaningful when the matching valid is high. They also assume that a collision can happen only while both readies are high, so a second collision never lands on an occupied holding register. The bench follows this from the ready outputs alone. It drives random valids, selectors and pops from a fixed seed, including valids raised during stall cycles. It also runs directed same-FIFO collisions, fills a FIFO past full, and pops empty FIFOs. Because pops are sparse, overflows occur often during the random runs.

// File: rtl/arr_pkg.sv
package arr_pkg;
  localparam int NUM_FIFO = 4;
  localparam int SEL_W    = 2;
  localparam int CHAN_W   = 4;

  typedef enum logic {
    SRC_UNIT_A = 1'b0,
    SRC_UNIT_B = 1'b1
  } src_unit_e;
endpackage

// File: rtl/arr_hold_reg.sv
module arr_hold_reg #(
  parameter int EW = 17,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [EW-1:0] load_entry,
  input  logic [SW-1:0] load_sel,
  output logic          full,
  output logic [EW-1:0] entry,
  output logic [SW-1:0] sel
);
  // The held entry always drains on the cycle after it is loaded.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      entry <= '0;
      sel   <= '0;
    end else begin
      full <= load;
      if (load) begin
        entry <= load_entry;
        sel   <= load_sel;
      end
    end
  end
endmodule

// File: rtl/arr_steer.sv
module arr_steer #(
  parameter int EW = 17,
  parameter int NF = 4,
  parameter int SW = 2
) (
  input  logic            hold_full,
  input  logic [EW-1:0]   hold_entry,
  input  logic [SW-1:0]   hold_sel,
  input  logic            a_valid,
  input  logic [EW-1:0]   a_entry,
  input  logic [SW-1:0]   a_sel,
  input  logic            b_valid,
  input  logic [EW-1:0]   b_entry,
  input  logic [SW-1:0]   b_sel,
  output logic            a_ready,
  output logic            b_ready,
  output logic            hold_load,
  output logic [NF-1:0]   wr_en,
  output logic [NF*EW-1:0] wr_entry
);
  logic a_acc, b_acc, clash;

  assign a_ready   = !hold_full;
  assign b_ready   = !hold_full;
  assign a_acc     = a_valid && !hold_full;
  assign b_acc     = b_valid && !hold_full;
  assign clash     = a_acc && b_acc && (a_sel == b_sel);
  assign hold_load = clash;

  for (genvar k = 0; k < NF; k++) begin : g_lane
    logic          en_k;
    logic [EW-1:0] ent_k;
    always_comb begin
      en_k  = 1'b0;
      ent_k = '0;
      if (hold_full) begin
        if (hold_sel == SW'(k)) begin
          en_k  = 1'b1;
          ent_k = hold_entry;
        end
      end else if (a_acc && a_sel == SW'(k)) begin
        en_k  = 1'b1;
        ent_k = a_entry;
      end else if (b_acc && b_sel == SW'(k)) begin
        en_k  = 1'b1;
        ent_k = b_entry;
      end
    end
    assign wr_en[k]              = en_k;
    assign wr_entry[k*EW +: EW]  = ent_k;
  end
endmodule

// File: rtl/arr_fifo.sv
module arr_fifo #(
  parameter int EW    = 17,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [EW-1:0] wr_data,
  input  logic          pop,
  output logic          avail,
  output logic [EW-1:0] head,
  output logic          ovf
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          is_full, do_push, do_pop;

  assign is_full = (cnt == CW'(DEPTH));
  assign avail   = (cnt != '0);
  assign do_push = wr && !is_full;
  assign do_pop  = pop && avail;
  assign head    = avail ? mem[rp] : '0;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (wr && is_full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/adc_result_router.sv
module adc_result_router
  import arr_pkg::*;
#(
  parameter int DW    = 12,
  parameter int DEPTH = 8,
  localparam int EW   = DW + CHAN_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   a_valid,
  output logic                   a_ready,
  input  logic [DW-1:0]          a_data,
  input  logic [CHAN_W-1:0]      a_chan,
  input  logic [SEL_W-1:0]       a_sel,
  input  logic                   b_valid,
  output logic                   b_ready,
  input  logic [DW-1:0]          b_data,
  input  logic [CHAN_W-1:0]      b_chan,
  input  logic [SEL_W-1:0]       b_sel,
  output logic [NUM_FIFO-1:0]    fifo_wr_en,
  output logic [NUM_FIFO*EW-1:0] fifo_wr_entry,
  input  logic [NUM_FIFO-1:0]    fifo_rd_pop,
  output logic [NUM_FIFO-1:0]    fifo_rd_valid,
  output logic [NUM_FIFO*EW-1:0] fifo_rd_data,
  output logic [NUM_FIFO-1:0]    fifo_ovf
);
  logic [EW-1:0]    a_entry, b_entry, hold_entry;
  logic [SEL_W-1:0] hold_sel;
  logic             hold_full, hold_load;

  assign a_entry = {SRC_UNIT_A, a_chan, a_data};
  assign b_entry = {SRC_UNIT_B, b_chan, b_data};

  arr_hold_reg #(.EW(EW), .SW(SEL_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load(hold_load), .load_entry(b_entry), .load_sel(b_sel),
    .full(hold_full), .entry(hold_entry), .sel(hold_sel)
  );

  arr_steer #(.EW(EW), .NF(NUM_FIFO), .SW(SEL_W)) u_steer (
    .hold_full(hold_full), .hold_entry(hold_entry), .hold_sel(hold_sel),
    .a_valid(a_valid), .a_entry(a_entry), .a_sel(a_sel),
    .b_valid(b_valid), .b_entry(b_entry), .b_sel(b_sel),
    .a_ready(a_ready), .b_ready(b_ready), .hold_load(hold_load),
    .wr_en(fifo_wr_en), .wr_entry(fifo_wr_entry)
  );

  for (genvar k = 0; k < NUM_FIFO; k++) begin : g_fifo
    arr_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr(fifo_wr_en[k]), .wr_data(fifo_wr_entry[k*EW +: EW]),
      .pop(fifo_rd_pop[k]),
      .avail(fifo_rd_valid[k]), .head(fifo_rd_data[k*EW +: EW]),
      .ovf(fifo_ovf[k])
    );
  end
endmodule

// File: rtl/arr_checker.sv
module arr_checker #(
  parameter int NF = 4,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_valid,
  input logic          a_ready,
  input logic [SW-1:0] a_sel,
  input logic          b_valid,
  input logic          b_ready,
  input logic [SW-1:0] b_sel,
  input logic [NF-1:0] fifo_wr_en,
  input logic [NF-1:0] fifo_rd_valid,
  input logic [NF-1:0] fifo_ovf
);
  logic both_acc;
  assign both_acc = a_valid && a_ready && b_valid && b_ready;

  p_split_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (both_acc && a_sel != b_sel) |-> (fifo_wr_en[a_sel] && fifo_wr_en[b_sel]));

  p_write_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fifo_wr_en) <= 2);

  p_defer_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (both_acc && a_sel == b_sel) |=> (fifo_wr_en == (NF'(1) << $past(b_sel))));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (both_acc && a_sel == b_sel) |=> (!a_ready && !b_ready));

  p_stall_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !a_ready |=> (a_ready && b_ready));

  p_sticky_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ovf & $past(fifo_ovf)) == $past(fifo_ovf));

  for (genvar k = 0; k < NF; k++) begin : g_nonempty
    p_written_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en[k] |=> fifo_rd_valid[k]);
  end
endmodule

bind adc_result_router arr_checker #(.NF(arr_pkg::NUM_FIFO), .SW(arr_pkg::SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_ready(a_ready), .a_sel(a_sel),
  .b_valid(b_valid), .b_ready(b_ready), .b_sel(b_sel),
  .fifo_wr_en(fifo_wr_en), .fifo_rd_valid(fifo_rd_valid), .fifo_ovf(fifo_ovf)
);

// File: tb/sim_adc_result_router.sv
module sim_adc_result_router;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;
  localparam int EW = DW + 5;
  localparam int NF = 4;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 0, b_valid = 0;
  logic a_ready, b_ready;
  logic [DW-1:0] a_data = '0, b_data = '0;
  logic [3:0] a_chan = '0, b_chan = '0;
  logic [1:0] a_sel = '0, b_sel = '0;
  logic [NF-1:0] fifo_wr_en, fifo_rd_valid, fifo_ovf;
  logic [NF-1:0] fifo_rd_pop = '0;
  logic [NF*EW-1:0] fifo_wr_entry, fifo_rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_result_router #(.DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_chan(a_chan), .a_sel(a_sel),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_chan(b_chan), .b_sel(b_sel),
    .fifo_wr_en(fifo_wr_en), .fifo_wr_entry(fifo_wr_entry),
    .fifo_rd_pop(fifo_rd_pop), .fifo_rd_valid(fifo_rd_valid),
    .fifo_rd_data(fifo_rd_data), .fifo_ovf(fifo_ovf)
  );

  int errors = 0;
  int checks = 0;

  // Reference model state
  logic [EW-1:0] mbuf [NF][DEPTH];
  int            mcnt [NF];
  logic [NF-1:0] movf;
  bit            mhold;
  logic [EW-1:0] mhent;
  logic [1:0]    mhsel;

  function automatic logic [EW-1:0] mk(input bit unit, input logic [3:0] ch, input logic [DW-1:0] d);
    return {unit, ch, d};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NF; k++) mcnt[k] = 0;
    movf = '0; mhold = 0; mhent = '0; mhsel = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; a_valid = 0; b_valid = 0; fifo_rd_pop = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
    #1;
    // R8: reset state
    chk(a_ready && b_ready, "R8", "readies", {a_ready, b_ready}, 2'b11);
    chk(fifo_rd_valid == 0, "R8", "rd_valid", fifo_rd_valid, 0);
    chk(fifo_ovf == 0, "R8", "ovf", fifo_ovf, 0);
    chk(fifo_wr_en == 0, "R8", "wr_en", fifo_wr_en, 0);
  endtask

  task automatic step(input bit av, input logic [DW-1:0] ad, input logic [3:0] ac, input logic [1:0] as,
                      input bit bv, input logic [DW-1:0] bd, input logic [3:0] bc, input logic [1:0] bs,
                      input logic [NF-1:0] pops);
    logic [NF-1:0] we;
    logic [EW-1:0] wv [NF];
    bit acc_a, acc_b, load;
    string lbl;
    @(negedge clk);
    a_valid = av; a_data = ad; a_chan = ac; a_sel = as;
    b_valid = bv; b_data = bd; b_chan = bc; b_sel = bs;
    fifo_rd_pop = pops;
    #1;
    // Expected writes
    we = '0; load = 0;
    for (int k = 0; k < NF; k++) wv[k] = '0;
    acc_a = av && !mhold;
    acc_b = bv && !mhold;
    lbl = "R5";
    if (mhold) begin
      we[mhsel] = 1; wv[mhsel] = mhent; lbl = "R3";
    end else begin
      if (acc_a) begin we[as] = 1; wv[as] = mk(1'b0, ac, ad); end
      if (acc_b) begin
        if (acc_a && as == bs) load = 1;
        else begin we[bs] = 1; wv[bs] = mk(1'b1, bc, bd); if (acc_a) lbl = "R2"; end
      end
    end
    chk(a_ready == !mhold && b_ready == !mhold, "R4", "readies", {a_ready, b_ready}, {!mhold, !mhold});
    chk(fifo_wr_en == we, lbl, "wr_en", fifo_wr_en, we);
    for (int k = 0; k < NF; k++) begin
      if (we[k]) chk(fifo_wr_entry[k*EW +: EW] == wv[k], "R1", "wr_entry", fifo_wr_entry[k*EW +: EW], wv[k]);
      chk(fifo_rd_valid[k] == (mcnt[k] > 0), "R6", "rd_valid", fifo_rd_valid[k], mcnt[k] > 0);
      if (mcnt[k] > 0)
        chk(fifo_rd_data[k*EW +: EW] == mbuf[k][0], "R6", "rd_data", fifo_rd_data[k*EW +: EW], mbuf[k][0]);
    end
    chk(fifo_ovf == movf, "R7", "ovf", fifo_ovf, movf);
    @(posedge clk);
    for (int k = 0; k < NF; k++) begin
      bit was_full;
      was_full = (mcnt[k] == DEPTH);
      if (pops[k] && mcnt[k] > 0) begin
        for (int i = 0; i < DEPTH - 1; i++) mbuf[k][i] = mbuf[k][i+1];
        mcnt[k]--;
      end
      if (we[k]) begin
        if (was_full) movf[k] = 1;
        else begin mbuf[k][mcnt[k]] = wv[k]; mcnt[k]++; end
      end
    end
    if (load) begin mhent = mk(1'b1, bc, bd); mhsel = bs; end
    mhold = load;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'd1234;
    void'($urandom(seed));
    do_reset();

    // R1: explicit packing, A alone to FIFO 2
    step(1, 12'hABC, 4'h5, 2'd2, 0, 0, 0, 0, 4'b0000);
    step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0000);
    chk(fifo_rd_data[2*EW +: EW] == {1'b0, 4'h5, 12'hABC}, "R1", "A packing",
        fifo_rd_data[2*EW +: EW], {1'b0, 4'h5, 12'hABC});
    step(0, 0, 0, 0, 1, 12'h123, 4'hE, 2'd1, 4'b0100);
    step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0000);
    chk(fifo_rd_data[1*EW +: EW] == {1'b1, 4'hE, 12'h123}, "R1", "B packing",
        fifo_rd_data[1*EW +: EW], {1'b1, 4'hE, 12'h123});

    // R2: different FIFOs in one cycle
    step(1, 12'h011, 4'h1, 2'd0, 1, 12'h022, 4'h2, 2'd3, 4'b0010);
    // R3/R4: same FIFO collision; B valid held during stall is ignored
    step(1, 12'h100, 4'h3, 2'd0, 1, 12'h200, 4'h4, 2'd0, 4'b0000);
    step(1, 12'h101, 4'h3, 2'd0, 1, 12'h201, 4'h4, 2'd0, 4'b0000);
    step(0, 0, 0, 0, 1, 12'h202, 4'h6, 2'd0, 4'b0000);
    // R5: B first, then A to the same FIFO one cycle later
    step(0, 0, 0, 0, 1, 12'h300, 4'h7, 2'd2, 4'b0000);
    step(1, 12'h301, 4'h8, 2'd2, 0, 0, 0, 0, 4'b0000);
    // R6: drain FIFO 0, then pop it while empty
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0101);
    // R7: overfill FIFO 3 with a pop on the full cycle
    for (int i = 0; i < 9; i++) step(1, DW'(i), 4'h9, 2'd3, 0, 0, 0, 0, 4'b0000);
    step(1, 12'hFFF, 4'h9, 2'd3, 0, 0, 0, 0, 4'b1000);
    step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0000);
    chk(fifo_ovf[3] == 1'b1, "R7", "ovf set", fifo_ovf[3], 1);

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      step($urandom_range(0, 99) < 60, DW'($urandom), 4'($urandom), 2'($urandom),
           $urandom_range(0, 99) < 60, DW'($urandom), 4'($urandom), 2'($urandom),
           ($urandom_range(0, 99) < 35) ? 4'($urandom) : 4'b0000);
    end
    for (int n = 0; n < 20; n++) step(0, 0, 0, 0, 0, 0, 0, 0, 4'b1111);

    // R7/R8: reset clears the sticky flags
    do_reset();
    step(0, 0, 0, 0, 0, 0, 0, 0, 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule